// File: doc/BRIEF.md
# Multi-Stream Capture Write Address Generator

This block generates system-memory write addresses for up to four capture streams: luma, two chroma, and ancillary. It also decides which stream uses a shared bus write port next. Each stream keeps a shadow base register that software may load at any time. At a frame boundary the shadow value is copied into the stream's running write pointer. The pointer then advances by one 64-bit word (8 bytes) for each beat the bus accepts.

A round-robin scheduler picks among streams whose FIFO holds enough data. It issues a four-beat burst request when a FIFO holds at least four words. It issues a single-beat request when an end-of-frame flush is requested and the FIFO holds one to three words. A request carries a raised priority flag when the requesting stream's fill level is above a programmable watermark. Every frame boundary produces a one-cycle interrupt pulse.

Only one transaction is in flight at a time. The address and write-valid appear only after the bus grants the request. Each accepted beat pops one word from the selected stream's FIFO.

Top module: `capwr_addr_gen`

## Requirements
- R1: After reset, req_o, wr_vld_o, irq_o and every bit of pop_o are 0, and every running pointer is 0.
- R2: A write to a stream's shadow base (base_we_i bit i with base_wdata_i) does not change the addresses used by that stream until the next frame boundary.
- R3: On frame_start_i, each running pointer is loaded with its shadow base as it stood before that cycle. A shadow write in the same cycle takes effect only at the following boundary.
- R4: irq_o is high for exactly the one cycle after each cycle with frame_start_i high.
- R5: During a transfer, wr_addr_o equals the selected stream's running pointer. The pointer advances by 8 on every accepted beat (beat_i high while wr_vld_o is high).
- R6: A stream whose fill count (fill_cnt_i bits [8*i+7:8*i]) is 4 or more requests a burst: req_burst_o=1, and the transfer is 4 beats.
- R7: A stream with a fill count of 1 to 3 requests only while flush_i is high, and then as a single beat (req_burst_o=0). A fill count of 0 never requests.
- R8: Streams are served round robin. After stream k is served, the next request goes to the first eligible stream in the order k+1, k+2, … (modulo 4). Stream 0 is first after reset.
- R9: req_o, req_stream_o and req_burst_o hold steady until gnt_i. wr_vld_o rises only in the cycle after a grant. No new request is raised until the current transfer's last beat is accepted.
- R10: While req_o is high, req_hi_pri_o is 1 exactly when the requesting stream's fill count is strictly greater than thresh_i.
- R11: pop_o has at most one bit set. That bit is the selected stream's, and only in a cycle where a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame boundary pulse |
| flush_i | input | 1 | End-of-frame flush: allow single-beat writes |
| base_we_i | input | NUM_STREAMS | Per-stream shadow base write strobe |
| base_wdata_i | input | ADDR_W | Shadow base write value |
| fill_cnt_i | input | NUM_STREAMS*CNT_W | Per-stream FIFO word counts, stream i at bits [CNT_W*i +: CNT_W] |
| thresh_i | input | CNT_W | Watermark for priority raise |
| req_o | output | 1 | Write request |
| req_stream_o | output | SID_W | Requesting stream index |
| req_burst_o | output | 1 | 1: four-beat burst, 0: single beat |
| req_hi_pri_o | output | 1 | Raised priority for the current request |
| gnt_i | input | 1 | Request granted |
| wr_vld_o | output | 1 | Data phase active, wr_addr_o valid |
| wr_addr_o | output | ADDR_W | Address of the current beat |
| beat_i | input | 1 | Current beat accepted |
| pop_o | output | NUM_STREAMS | Per-stream FIFO pop strobe |
| irq_o | output | 1 | Frame boundary interrupt pulse |

## Verification
A corrupted running pointer shows on wr_addr_o at the next data beat of that stream, at the latest on its first transfer after the fault. Such an error persists until the next frame boundary reloads the pointer. A wrong shadow value stays hidden until the next frame boundary, so the bench places bursts on both sides of each boundary. A bad round-robin pointer or eligibility decode shows as the wrong req_stream_o or req_burst_o on the very next request. A sequencer fault shows within one beat as a missing or extra pop_o bit or a wrong beat count.

// File: rtl/capwr_pkg.sv
package capwr_pkg;
  localparam int unsigned WORD_BYTES  = 8;
  localparam int unsigned BURST_BEATS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/capwr_stream_addr.sv
module capwr_stream_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  logic              frame_start_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic [ADDR_W-1:0] shadow_q;
  logic [ADDR_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (base_we_i) shadow_q <= base_wdata_i;
  end

  // frame reload wins over a same-cycle advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (frame_start_i) cur_q <= shadow_q;
    else if (adv_i) cur_q <= cur_q + ADDR_W'(STEP);
  end

  assign cur_addr_o = cur_q;

  // R3
  frame_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> cur_q == $past(shadow_q));

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !frame_start_i) |=> cur_q == $past(cur_q) + ADDR_W'(STEP));

  // R2
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !adv_i) |=> $stable(cur_q));
endmodule

// File: rtl/capwr_rr_arb.sv
module capwr_rr_arb #(
  parameter int unsigned N    = 4,
  localparam int unsigned SW  = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          accept_i,
  output logic [N-1:0]  gnt_o,
  output logic [SW-1:0] idx_o,
  output logic          any_o
);
  logic [SW-1:0] last_q;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int off = 1; off <= int'(N); off++) begin
      if (!any_o && req_i[(int'(last_q) + off) % int'(N)]) begin
        any_o = 1'b1;
        idx_o = SW'((int'(last_q) + off) % int'(N));
        gnt_o[(int'(last_q) + off) % int'(N)] = 1'b1;
      end
    end
  end

  // start so that stream 0 wins first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= SW'(N - 1);
    else if (accept_i && any_o) last_q <= idx_o;
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (any_o == (req_i != '0)));

  // R8
  gnt_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> (gnt_o & req_i) != '0);
endmodule

// File: rtl/capwr_addr_gen.sv
module capwr_addr_gen
  import capwr_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 8,
  localparam int unsigned SID_W      = $clog2(NUM_STREAMS),
  localparam int unsigned BEAT_W     = $clog2(BURST_BEATS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         frame_start_i,
  input  logic                         flush_i,
  input  logic [NUM_STREAMS-1:0]       base_we_i,
  input  logic [ADDR_W-1:0]            base_wdata_i,
  input  logic [NUM_STREAMS*CNT_W-1:0] fill_cnt_i,
  input  logic [CNT_W-1:0]             thresh_i,
  output logic                         req_o,
  output logic [SID_W-1:0]             req_stream_o,
  output logic                         req_burst_o,
  output logic                         req_hi_pri_o,
  input  logic                         gnt_i,
  output logic                         wr_vld_o,
  output logic [ADDR_W-1:0]            wr_addr_o,
  input  logic                         beat_i,
  output logic [NUM_STREAMS-1:0]       pop_o,
  output logic                         irq_o
);
  xfer_state_e       state_q;
  logic [SID_W-1:0]  sel_q;
  logic              burst_q;
  logic [BEAT_W-1:0] beat_cnt_q;
  logic              irq_q;

  logic [CNT_W-1:0]       fill [NUM_STREAMS];
  logic [ADDR_W-1:0]      cur_addr [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] elig, big, adv, arb_gnt;
  logic [SID_W-1:0]       arb_idx;
  logic                   arb_any, start, last_beat, beat_acc;

  assign beat_acc = (state_q == ST_XFER) && beat_i;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
    assign fill[i] = fill_cnt_i[CNT_W*i +: CNT_W];
    assign big[i]  = fill[i] >= CNT_W'(BURST_BEATS);
    assign elig[i] = big[i] || (flush_i && (fill[i] != '0));
    assign adv[i]  = beat_acc && (sel_q == SID_W'(i));

    capwr_stream_addr #(
      .ADDR_W (ADDR_W),
      .STEP   (WORD_BYTES)
    ) u_addr (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .base_we_i     (base_we_i[i]),
      .base_wdata_i  (base_wdata_i),
      .frame_start_i (frame_start_i),
      .adv_i         (adv[i]),
      .cur_addr_o    (cur_addr[i])
    );
  end

  // hold off a new pick while pointers reload
  assign start = (state_q == ST_IDLE) && arb_any && !frame_start_i;

  capwr_rr_arb #(.N(NUM_STREAMS)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (elig),
    .accept_i (start),
    .gnt_o    (arb_gnt),
    .idx_o    (arb_idx),
    .any_o    (arb_any)
  );

  assign last_beat = !burst_q || (beat_cnt_q == BEAT_W'(BURST_BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      burst_q    <= 1'b0;
      beat_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          sel_q   <= arb_idx;
          burst_q <= |(arb_gnt & big);
          state_q <= ST_REQ;
        end
        ST_REQ: if (gnt_i) begin
          beat_cnt_q <= '0;
          state_q    <= ST_XFER;
        end
        ST_XFER: if (beat_i) begin
          beat_cnt_q <= beat_cnt_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= frame_start_i;
  end

  assign req_o        = (state_q == ST_REQ);
  assign req_stream_o = sel_q;
  assign req_burst_o  = burst_q;
  assign req_hi_pri_o = req_o && (fill[sel_q] > thresh_i);
  assign wr_vld_o     = (state_q == ST_XFER);
  assign wr_addr_o    = cur_addr[sel_q];
  assign pop_o        = adv;
  assign irq_o        = irq_q;

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(req_stream_o) && $stable(req_burst_o)));

  // R9
  data_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_vld_o) |-> $past(req_o && gnt_i));

  // R9
  no_req_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && wr_vld_o));

  // R11
  pop_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o) && ((pop_o != '0) == (wr_vld_o && beat_i)));

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> irq_o);

  // R4
  irq_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i) |=> !irq_o);
endmodule

// File: tb/capwr_addr_gen_bench.sv
`timescale 1ns/1ps
module capwr_addr_gen_bench;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, flush = 1'b0;
  logic [NS-1:0] base_we = '0;
  logic [AW-1:0] base_wdata = '0;
  logic [NS*CW-1:0] fill_flat;
  logic [CW-1:0] thresh = 8'd255;
  logic req, req_burst, req_hi, gnt = 1'b0, wr_vld, beat = 1'b0, irq;
  logic [1:0] req_sid;
  logic [AW-1:0] wr_addr;
  logic [NS-1:0] pop;

  logic [CW-1:0] fill [NS];
  logic [AW-1:0] exp_cur [NS];
  logic [AW-1:0] pend [NS];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NS; i++) fill_flat[CW*i +: CW] = fill[i];

  capwr_addr_gen u_capwr_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .flush_i(flush),
    .base_we_i(base_we), .base_wdata_i(base_wdata), .fill_cnt_i(fill_flat),
    .thresh_i(thresh), .req_o(req), .req_stream_o(req_sid), .req_burst_o(req_burst),
    .req_hi_pri_o(req_hi), .gnt_i(gnt), .wr_vld_o(wr_vld), .wr_addr_o(wr_addr),
    .beat_i(beat), .pop_o(pop), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_base(input int sid, input logic [AW-1:0] v);
    base_we = NS'(1) << sid; base_wdata = v;
    step();
    base_we = '0;
    pend[sid] = v;
  endtask

  // frame pulse, optionally with a same-cycle shadow write
  task automatic frame(input int we_sid, input logic [AW-1:0] v);
    frame_start = 1'b1;
    if (we_sid >= 0) begin base_we = NS'(1) << we_sid; base_wdata = v; end
    step();
    frame_start = 1'b0; base_we = '0;
    for (int i = 0; i < NS; i++) exp_cur[i] = pend[i];
    if (we_sid >= 0) pend[we_sid] = v;
    chk(irq === 1'b1, "R4 irq after frame", irq, 1);
    step();
    chk(irq === 1'b0, "R4 irq single cycle", irq, 0);
  endtask

  task automatic serve(input int sid, input bit burst, input int delay, input int hp, input string tag);
    int n;
    int t = 0;
    while (!req && t < 40) begin step(); t++; end
    chk(req === 1'b1, {tag, " request seen"}, req, 1);
    chk(req_sid == 2'(sid), {tag, " stream"}, req_sid, sid);
    chk(req_burst === burst, burst ? "R6 burst flag" : "R7 single flag", req_burst, burst);
    if (hp >= 0) chk(req_hi === 1'(hp), "R10 priority", req_hi, hp);
    for (int d = 0; d < delay; d++) begin
      step();
      chk(req && req_sid == 2'(sid) && req_burst == burst && !wr_vld, "R9 hold until grant",
          {req, wr_vld}, 2'b10);
    end
    gnt = 1'b1;
    step();
    gnt = 1'b0;
    chk(wr_vld === 1'b1 && !req, "R9 data after grant", {req, wr_vld}, 2'b01);
    n = burst ? 4 : 1;
    for (int k = 0; k < n; k++) begin
      chk(wr_addr == exp_cur[sid], "R5 beat address", wr_addr, exp_cur[sid]);
      beat = 1'b1;
      #1;
      chk(pop == (NS'(1) << sid), "R11 pop strobe", pop, NS'(1) << sid);
      @(posedge clk); #1;
      beat = 1'b0;
      exp_cur[sid] = exp_cur[sid] + 8;
      fill[sid] = fill[sid] - 1;
    end
    chk(!wr_vld && pop == '0, "R6 beat count", {wr_vld, pop}, 0);
  endtask

  task automatic t_reset();
    chk(!req && !wr_vld && !irq && pop == '0, "R1 reset outputs", {req, wr_vld, irq, pop}, 0);
  endtask

  task automatic t_frame_swap();
    write_base(0, 32'h1000_0000);
    write_base(1, 32'h2000_0000);
    write_base(2, 32'h3000_0000);
    write_base(3, 32'h4000_0000);
    fill[0] = 4;
    serve(0, 1, 0, -1, "R2 pre-frame pointer");
    frame(-1, '0);
    fill[0] = 4;
    serve(0, 1, 0, -1, "R3 new base");
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < NS; i++) fill[i] = 8;
    serve(1, 1, 0, -1, "R8 rr");
    serve(2, 1, 0, -1, "R8 rr");
    serve(3, 1, 0, -1, "R8 rr");
    serve(0, 1, 0, -1, "R8 rr");
    serve(1, 1, 0, -1, "R8 rr");
    serve(2, 1, 0, -1, "R8 rr");
    serve(3, 1, 0, -1, "R8 rr");
    serve(0, 1, 0, -1, "R8 rr");
  endtask

  task automatic t_shadow();
    write_base(1, 32'h9000_0000);
    fill[1] = 4;
    serve(1, 1, 0, -1, "R2 shadow ignored");
    frame(0, 32'hA000_0000);
    fill[1] = 4;
    serve(1, 1, 0, -1, "R3 reload");
    fill[0] = 4;
    serve(0, 1, 0, -1, "R3 same-cycle write deferred");
    frame(-1, '0);
    fill[0] = 4;
    serve(0, 1, 0, -1, "R3 deferred write lands");
  endtask

  task automatic t_flush();
    fill[2] = 2;
    for (int c = 0; c < 6; c++) begin
      step();
      chk(!req && !wr_vld, "R7 partial without flush", req, 0);
    end
    flush = 1'b1;
    serve(2, 0, 0, -1, "R7 flush single");
    serve(2, 0, 0, -1, "R7 flush single");
    for (int c = 0; c < 4; c++) begin
      step();
      chk(!req, "R7 empty no request", req, 0);
    end
    flush = 1'b0;
  endtask

  task automatic t_priority();
    thresh = 8'd4;
    fill[3] = 8;
    serve(3, 1, 3, 1, "R10 above watermark");
    serve(3, 1, 2, 0, "R10 at watermark");
    thresh = 8'd255;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin fill[i] = '0; exp_cur[i] = '0; pend[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_frame_swap();
    t_round_robin();
    t_shadow();
    t_flush();
    t_priority();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule